// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns characters written by software into asynchronous serial frames on a single output line. It has two storage stages: a one-character holding register that software writes, and a shift register that drives the line. When the shift register finishes a frame and a character is waiting, the waiting character starts in the same clock edge, so consecutive frames follow each other with no idle time on the line.

The frame shape is set by configuration inputs: 5 to 9 data bits, optional even or odd parity, and one or two stop bits. A ninth data bit is staged through its own write strobe ahead of the low byte. Two status outputs tell software when the holding register can take a character and when the line has gone quiet with nothing left to send. Dropping the enable input does not cut a frame short. The block keeps driving until both stages are empty, and only then releases the line by lowering its output-enable. Bit timing comes from an external baud tick, with sixteen ticks per bit.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset `txd` is 1, `txd_oe` is 0, `buf_empty` is 1 and `tx_done` is 0.
- R2: A frame is one low start bit, then the data bits with the least significant bit first, then a parity bit if `par_en` is 1, then one stop bit, or two if `two_stop` is 1. Stop bits are high and the line idles high. Each bit lasts 16 accepted `baud_tick` pulses. `char_bits` holds the data bit count 5 to 9. Values below 5 act as 5 and values above 9 act as 9.
- R3: A `wr_data` pulse is taken only while `buf_empty` is 1 and `tx_en` is 1. In every other case it changes neither the status outputs nor the line.
- R4: For fewer than 8 data bits, the bits of `wr_byte` above the data length never reach the line.
- R5: With 9 data bits, the ninth bit sent is the value of `bit9_in` captured by the most recent `wr_bit9` pulse before the byte write.
- R6: `buf_empty` goes to 0 on the edge that accepts a write. It returns to 1 on the edge where the character moves into the shift register.
- R7: A character that is waiting when the last stop bit ends has its start bit begin on that same edge. The time between the two start edges is then exactly 16 ticks times the first frame's bit count.
- R8: `tx_done` goes to 1 when a frame's last stop bit ends and no character is waiting. It stays 0 across a back-to-back handover.
- R9: `tx_done` clears on a `clr_done` pulse or on an accepted write. A write accepted on the very edge that ends the last frame keeps `tx_done` at 0, and that character is sent next.
- R10: Parity is computed over the data bits. It is even parity when `par_odd` is 0 and odd parity when `par_odd` is 1.
- R11: While `tx_en` is 0, `txd_oe` stays 1 until both stages are empty. Once they are, `txd_oe` drops to 0 and `txd` stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmitter enable |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit |
| wr_data | input | 1 | Write strobe for the low byte |
| wr_byte | input | 8 | Low byte of the character |
| wr_bit9 | input | 1 | Write strobe for the staged ninth bit |
| bit9_in | input | 1 | Ninth bit value |
| clr_done | input | 1 | Write-one pulse that clears `tx_done` |
| char_bits | input | 4 | Data bit count, 5 to 9 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop | input | 1 | 1 selects two stop bits |
| txd | output | 1 | Serial line |
| txd_oe | output | 1 | Line output-enable |
| buf_empty | output | 1 | Holding register can take a character |
| tx_done | output | 1 | Line quiet with nothing queued |

## Verification
The delicate overlap is a software write that lands on the same edge as the end of the last stop bit while the holding register is empty. On that edge the done flag would be set and the write would clear it. The bench counts baud ticks from the load edge and raises `wr_data` exactly for the ending edge. It then checks that `tx_done` stays 0 and `buf_empty` goes to 0, and that the scoreboard receives the new frame intact. A related overlap, the pending character loading as the previous frame ends, is judged by counting ticks between the two start edges.

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       baud_tick,
  input  logic       wr_data,
  input  logic [7:0] wr_byte,
  input  logic       wr_bit9,
  input  logic       bit9_in,
  input  logic       clr_done,
  input  logic [3:0] char_bits,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       two_stop,
  output logic       txd,
  output logic       txd_oe,
  output logic       buf_empty,
  output logic       tx_done
);
  localparam int FRAME_W = 13;
  localparam int TW = $clog2(TICKS_PER_BIT);
  localparam int LW = $clog2(FRAME_W + 1);

  logic [3:0]         nb, par_pos;
  logic [8:0]         mask, hold_data;
  logic               stage9, hold_full, busy, active, done_q;
  logic [FRAME_W-1:0] shr, frame;
  logic [LW-1:0]      bits_left, frame_len;
  logic [TW-1:0]      tick_cnt;

  assign nb      = (char_bits < 4'd5) ? 4'd5 : (char_bits > 4'd9) ? 4'd9 : char_bits;
  assign mask    = (9'h1 << nb) - 9'h1;
  assign par_pos = nb + 4'd1;

  wire accept    = wr_data && tx_en && !hold_full;
  wire bit_end   = busy && baud_tick && (tick_cnt == TW'(TICKS_PER_BIT - 1));
  wire frame_end = bit_end && (bits_left == LW'(1));
  wire load      = hold_full && (!busy || frame_end);

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int k = 0; k < 9; k++)
      if (k < int'(nb)) frame[4'(k + 1)] = hold_data[4'(k)];
    if (par_en) frame[par_pos] = par_odd ^ (^hold_data);
    frame_len = LW'(nb) + LW'(2) + LW'(par_en) + LW'(two_stop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage9    <= 1'b0;
      hold_data <= '0;
      hold_full <= 1'b0;
      busy      <= 1'b0;
      shr       <= '1;
      bits_left <= '0;
      tick_cnt  <= '0;
      done_q    <= 1'b0;
      active    <= 1'b0;
    end else begin
      if (wr_bit9) stage9 <= bit9_in;

      if (accept) begin
        hold_data <= {stage9, wr_byte} & mask;
        hold_full <= 1'b1;
      end else if (load) begin
        hold_full <= 1'b0;
      end

      if (load) begin
        shr       <= frame;
        bits_left <= frame_len;
        tick_cnt  <= '0;
        busy      <= 1'b1;
      end else if (busy && baud_tick) begin
        if (bit_end) begin
          shr       <= {1'b1, shr[FRAME_W-1:1]};
          bits_left <= bits_left - LW'(1);
          tick_cnt  <= '0;
          if (frame_end) busy <= 1'b0;
        end else begin
          tick_cnt <= tick_cnt + TW'(1);
        end
      end

      if (frame_end && !hold_full && !accept) done_q <= 1'b1;
      else if (accept || clr_done)            done_q <= 1'b0;

      if (tx_en)                     active <= 1'b1;
      else if (!hold_full && !busy)  active <= 1'b0;
    end
  end

  assign txd       = busy ? shr[0] : 1'b1;
  assign txd_oe    = active;
  assign buf_empty = !hold_full;
  assign tx_done   = done_q;

  assert_fill_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !buf_empty);
  assert_hold_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !load) |=> $stable(hold_data));
  assert_handover_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && hold_full) |=> (busy && !txd && !tx_done));
  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> (buf_empty && txd));
  assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd_oe) |-> (!busy && buf_empty && !$past(tx_en)));
  assert_line_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !txd_oe |-> txd);
endmodule

// File: tb/uart_tx_dbuf_test.sv
module uart_tx_dbuf_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int BITC       = 16 * TICK_DIV;

  logic clk = 0, rst_n = 0, tx_en = 0, baud_tick = 0;
  logic wr_data = 0, wr_bit9 = 0, bit9_in = 0, clr_done = 0;
  logic [7:0] wr_byte = 0;
  logic [3:0] char_bits = 4'd8;
  logic par_en = 0, par_odd = 0, two_stop = 0;
  logic txd, txd_oe, buf_empty, tx_done;

  uart_tx_dbuf #(.TICKS_PER_BIT(16)) uut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .baud_tick(baud_tick),
    .wr_data(wr_data), .wr_byte(wr_byte), .wr_bit9(wr_bit9), .bit9_in(bit9_in),
    .clr_done(clr_done), .char_bits(char_bits), .par_en(par_en), .par_odd(par_odd),
    .two_stop(two_stop), .txd(txd), .txd_oe(txd_oe), .buf_empty(buf_empty),
    .tx_done(tx_done));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) baud_tick <= ~baud_tick;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  logic [12:0] q_bits[$];
  int          q_len[$];
  bit          q_b2b[$];
  string       q_req[$];

  function automatic int expect_frame(input logic [8:0] d, input bit b2b, input string req);
    int nb;
    logic [12:0] b;
    bit p;
    nb = (char_bits < 5) ? 5 : (char_bits > 9) ? 9 : int'(char_bits);
    b = '1; b[0] = 1'b0; p = par_odd;
    for (int i = 0; i < nb; i++) begin b[i+1] = d[i]; p ^= d[i]; end
    if (par_en) b[nb+1] = p;
    q_bits.push_back(b);
    q_len.push_back(nb + 2 + int'(par_en) + int'(two_stop));
    q_b2b.push_back(b2b);
    q_req.push_back(req);
    return nb + 2 + int'(par_en) + int'(two_stop);
  endfunction

  // monitor: pops the expected frame at each start edge, samples mid-bit
  bit inframe = 0, prevtxd = 1, m_b2b;
  int cnt, bitidx, m_len, last_len = 0, tk = 0;
  logic [12:0] m_exp, got;
  string m_req;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!inframe && prevtxd && !txd) begin
        if (q_len.size() == 0) begin
          check(0, "R3", "unexpected frame on line", 1, 0);
        end else begin
          m_exp = q_bits.pop_front(); m_len = q_len.pop_front();
          m_b2b = q_b2b.pop_front();  m_req = q_req.pop_front();
          if (m_b2b) check(tk == 16 * last_len, "R7", "ticks between start edges", tk, 16 * last_len);
          last_len = m_len; tk = 0; inframe = 1; bitidx = 0; cnt = BITC / 2; got = '1;
        end
      end else if (inframe) begin
        cnt--;
        if (cnt == 0) begin
          got[bitidx] = txd; bitidx++; cnt = BITC;
          if (bitidx == m_len) begin
            inframe = 0;
            check(got == m_exp, m_req, "frame bits", int'(got), int'(m_exp));
          end
        end
      end
      prevtxd = txd;
      tk += int'(baud_tick);
    end
  end

  task automatic send(input logic [7:0] b, input bit b9, input bit b2b, input string req);
    int dummy;
    @(negedge clk);
    while (!buf_empty) @(negedge clk);
    if (char_bits >= 9) begin
      wr_bit9 = 1; bit9_in = b9; @(negedge clk); wr_bit9 = 0;
    end
    wr_byte = b; wr_data = 1;
    dummy = expect_frame({b9, b} & ((9'h1 << ((char_bits < 5) ? 5 : (char_bits > 9) ? 9 : char_bits)) - 9'h1), b2b, req);
    @(negedge clk); wr_data = 0;
  endtask

  task automatic wait_done();
    while (!tx_done) @(negedge clk);
  endtask

  task automatic drain();
    while (q_len.size() != 0 || inframe) @(negedge clk);
  endtask

  initial begin
    int n, len;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(txd == 1, "R1", "txd after reset", txd, 1);
    check(txd_oe == 0, "R1", "txd_oe after reset", txd_oe, 0);
    check(buf_empty == 1, "R1", "buf_empty after reset", buf_empty, 1);
    check(tx_done == 0, "R1", "tx_done after reset", tx_done, 0);

    // R3: write while disabled ignored
    wr_byte = 8'h55; wr_data = 1; @(negedge clk); wr_data = 0;
    @(negedge clk);
    check(buf_empty == 1, "R3", "buf_empty after disabled write", buf_empty, 1);
    check(txd_oe == 0, "R3", "txd_oe after disabled write", txd_oe, 0);

    tx_en = 1;
    @(negedge clk);
    check(txd_oe == 1, "R11", "txd_oe after enable", txd_oe, 1);

    // R2 basic 8N1
    send(8'hA5, 0, 0, "R2");
    check(buf_empty == 0, "R6", "buf_empty right after write", buf_empty, 0);
    @(negedge clk);
    check(buf_empty == 1, "R6", "buf_empty after load", buf_empty, 1);
    wait_done();
    check(buf_empty == 1, "R8", "buf_empty with done", buf_empty, 1);
    drain();
    clr_done = 1; @(negedge clk); clr_done = 0;
    check(tx_done == 0, "R9", "tx_done after clr_done", tx_done, 0);

    // R4/R10: 7 bits even parity, high bit dropped
    char_bits = 4'd7; par_en = 1; par_odd = 0;
    send(8'hFF, 0, 0, "R4");
    wait_done(); drain();
    // R10 odd parity, 5 bits, two stop
    char_bits = 4'd5; par_odd = 1; two_stop = 1;
    send(8'h3B, 0, 0, "R10");
    wait_done(); drain();
    check(tx_done == 1, "R8", "tx_done after frame", tx_done, 1);
    // R9: write clears done
    char_bits = 4'd9; par_en = 0; two_stop = 0;
    send(8'h3C, 1, 0, "R5");
    check(tx_done == 0, "R9", "tx_done after accepted write", tx_done, 0);
    wait_done(); drain();
    send(8'hC3, 0, 0, "R5");
    wait_done(); drain();

    // R7/R8 back-to-back, write while full ignored
    char_bits = 4'd8; clr_done = 1; @(negedge clk); clr_done = 0;
    send(8'h81, 0, 0, "R7");
    send(8'h7E, 0, 1, "R7");
    check(buf_empty == 0, "R6", "buf_empty while queued", buf_empty, 0);
    wr_byte = 8'h00; wr_data = 1; @(negedge clk); wr_data = 0;
    check(buf_empty == 0, "R3", "buf_empty after write to full", buf_empty, 0);
    while (inframe == 0) @(negedge clk);
    while (q_len.size() != 0) @(negedge clk);
    check(tx_done == 0, "R8", "tx_done during handover", tx_done, 0);
    wait_done(); drain();

    // R9 collision: write on the edge that ends the last frame
    clr_done = 1; @(negedge clk); clr_done = 0;
    wr_byte = 8'h96; wr_data = 1;
    len = expect_frame(9'h096, 0, "R9");
    @(negedge clk); wr_data = 0;
    n = 0;
    while (n < 16 * len) begin @(negedge clk); if (baud_tick) n++; end
    wr_byte = 8'h69; wr_data = 1;
    len = expect_frame(9'h069, 0, "R9");
    @(negedge clk); wr_data = 0;
    check(tx_done == 0, "R9", "tx_done after write at frame end", tx_done, 0);
    check(buf_empty == 0, "R9", "buf_empty after write at frame end", buf_empty, 0);
    wait_done(); drain();

    // R11 deferred disable
    send(8'h11, 0, 0, "R11");
    send(8'h22, 0, 1, "R11");
    tx_en = 0;
    repeat (BITC * 4) @(negedge clk);
    check(txd_oe == 1, "R11", "txd_oe while data queued", txd_oe, 1);
    wait_done();
    check(txd_oe == 1, "R11", "txd_oe as last frame ends", txd_oe, 1);
    repeat (2) @(negedge clk);
    check(txd_oe == 0, "R11", "txd_oe after drain", txd_oe, 0);
    check(txd == 1, "R11", "txd after release", txd, 1);
    drain();
    finished = 1;
  end

  initial begin
    int c;
    c = 0;
    while (!finished && c < 150000) begin @(posedge clk); c++; end
    if (!finished) check(0, "R1", "watchdog expired", c, 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule